// File: doc/BRIEF.md
# Encoded-Time Control Strobe Generator

This block produces timed, active-low control strobes that move data between registers. A small phase counter, clocked by the master clock, walks through an encoded-time code. A shared decoder turns that code into one-hot phase products. A bank of sequencers then forms each control output as the OR of the phase products selected for it, and each sequencer is gated by its own strobe input. Instruction decoding outside the block raises exactly one strobe for as many cycles as the wanted sequence lasts.

The phase code is two bits wide by default, which gives four phases (T1..T4). A parameter widens it to three bits, which gives eight phases, so sequences can run from one up to eight master-clock periods. The phase counter sits at T1 whenever no strobe is raised, so every sequence begins at T1. Outputs are registered after the sum-of-products logic, so a change of the phase code cannot glitch a strobe.

Top module: `phaseSeqGen`

## Requirements
- R1: While rstN is low, every bit of ctlN is 1 (inactive) and phaseCode is 0, whatever seqStrobe carries.
- R2: In a cycle where no seqStrobe bit is 1, phaseCode returns to 0 (phase T1) at the next clock edge and stays there.
- R3: At each clock edge where any seqStrobe bit is 1, phaseCode increments by one, wrapping from the last phase (NUM_PHASES-1) to 0. It keeps counting when the strobe passes from one sequencer straight to another.
- R4: Phase code value p stands for phase T(p+1). For sequencer s, output o sits at ctlN bit s*NUM_OUT+o. It is 0 in the cycle after an edge where seqStrobe[s] was 1 and phaseCode was p, if and only if OUT_MASK bit (s*NUM_OUT+o)*NUM_PHASES+p is 1.
- R5: With the default mask, sequencer 0 performs a memory-to-register load. Its address enable (output 0) is low in T1 to T3, its memory read (output 1) in T2 to T3, and its register load (output 2) in T3 only.
- R6: The outputs of any sequencer whose strobe is 0 stay 1. This also holds while another sequencer is running.
- R7: All control outputs are active low. One edge after a sequencer's strobe returns to 0, all of its outputs are 1.
- R8: At most one seqStrobe bit may be 1 in any cycle. Consequently, at most one sequencer has any output low at a time.
- R9: With PHASE_BITS = 3, eight phases are decoded, so an output can be held low for eight consecutive cycles and an output can be placed in T8 alone.
- R10: A strobe held for one cycle produces exactly the T1 pattern for one cycle, followed by all outputs inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| seqStrobe | input | NUM_SEQ | One enable per sequencer, active high, at most one set |
| ctlN | output | NUM_SEQ*NUM_OUT | Registered active-low control strobes, sequencer-major |
| phaseCode | output | PHASE_BITS | Current encoded-time code (0 = T1) |

## Verification
On every cycle, the assertions check the following. The counter returns to T1 when idle and steps by one while strobed. The decoded phase products are exactly one-hot. An unstrobed sequencer keeps its outputs high. Strobes never overlap, and no two sequencers drive low outputs together. Only the bench scenarios can show the actual phase-by-phase shape of each sequence: the memory-load pattern, the wrap after the last phase, the single-cycle strobe, the hand-off between sequencers without an idle cycle, and the eight-phase variant.

// File: rtl/seqGenPkg.sv
package seqGenPkg;
  // Widest phase decode supported (three encoded-time bits)
  localparam int MAX_PHASES = 8;

  // Control-to-datapath bundle: one-hot phase products
  typedef struct packed {
    logic [MAX_PHASES-1:0] phaseHot;
  } phaseBus_t;
endpackage

// File: rtl/phaseCtl.sv
module phaseCtl
  import seqGenPkg::*;
#(
  parameter int PHASE_BITS = 2,
  parameter int NUM_SEQ    = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_SEQ-1:0]    seqStrobe,
  output phaseBus_t             phaseBus,
  output logic [PHASE_BITS-1:0] phaseCode
);
  localparam int NUM_PHASES = 1 << PHASE_BITS;

  logic anyStrobe;
  logic [PHASE_BITS-1:0] phaseCnt;

  assign anyStrobe = |seqStrobe;

  // Free-running while strobed, parked at T1 when idle
  always_ff @(posedge clk) begin
    if (!rstN)          phaseCnt <= '0;
    else if (anyStrobe) phaseCnt <= phaseCnt + 1'b1;
    else                phaseCnt <= '0;
  end

  assign phaseCode = phaseCnt;

  // Shared product decoder
  for (genvar p = 0; p < MAX_PHASES; p++) begin : g_prod
    if (p < NUM_PHASES) begin : g_used
      assign phaseBus.phaseHot[p] = (phaseCnt == PHASE_BITS'(p));
    end else begin : g_unused
      assign phaseBus.phaseHot[p] = 1'b0;
    end
  end

  // R2
  idle_park_chk: assert property (@(posedge clk) disable iff (!rstN)
    !anyStrobe |=> (phaseCode == '0));

  // R3
  phase_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |=> (phaseCode == PHASE_BITS'($past(phaseCode) + 1'b1)));
endmodule

// File: rtl/seqUnit.sv
module seqUnit
  import seqGenPkg::*;
#(
  parameter int NUM_OUT    = 3,
  parameter int NUM_PHASES = 4,
  parameter logic [NUM_OUT*NUM_PHASES-1:0] UNIT_MASK = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               strobe,
  input  phaseBus_t          phaseBus,
  output logic [NUM_OUT-1:0] ctlN
);
  logic [NUM_OUT-1:0] sumTerm;

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic [MAX_PHASES-1:0] maskExt;
    assign maskExt    = MAX_PHASES'(UNIT_MASK[o*NUM_PHASES +: NUM_PHASES]);
    assign sumTerm[o] = |(maskExt & phaseBus.phaseHot);
  end

  // Registered, active-low, gated by this unit's strobe
  always_ff @(posedge clk) begin
    if (!rstN) ctlN <= '1;
    else       ctlN <= ~(sumTerm & {NUM_OUT{strobe}});
  end

  // R6
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe |=> (&ctlN));

  // R4
  phase_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(phaseBus.phaseHot) == 1);
endmodule

// File: rtl/seqBank.sv
module seqBank
  import seqGenPkg::*;
#(
  parameter int NUM_SEQ    = 2,
  parameter int NUM_OUT    = 3,
  parameter int NUM_PHASES = 4,
  parameter logic [NUM_SEQ*NUM_OUT*NUM_PHASES-1:0] OUT_MASK = '0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SEQ-1:0]         seqStrobe,
  input  phaseBus_t                  phaseBus,
  output logic [NUM_SEQ*NUM_OUT-1:0] ctlN
);
  localparam int UNIT_W = NUM_OUT * NUM_PHASES;

  logic [NUM_SEQ-1:0] groupActive;

  for (genvar s = 0; s < NUM_SEQ; s++) begin : g_seq
    seqUnit #(
      .NUM_OUT   (NUM_OUT),
      .NUM_PHASES(NUM_PHASES),
      .UNIT_MASK (OUT_MASK[s*UNIT_W +: UNIT_W])
    ) i_seqUnit (
      .clk     (clk),
      .rstN    (rstN),
      .strobe  (seqStrobe[s]),
      .phaseBus(phaseBus),
      .ctlN    (ctlN[s*NUM_OUT +: NUM_OUT])
    );
    assign groupActive[s] = ~&ctlN[s*NUM_OUT +: NUM_OUT];
  end

  // R8
  single_driver_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(groupActive));
endmodule

// File: rtl/phaseSeqGen.sv
module phaseSeqGen
  import seqGenPkg::*;
#(
  parameter int PHASE_BITS = 2,
  parameter int NUM_SEQ    = 2,
  parameter int NUM_OUT    = 3,
  parameter logic [NUM_SEQ*NUM_OUT*(1<<PHASE_BITS)-1:0] OUT_MASK = 24'h823467
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SEQ-1:0]         seqStrobe,
  output logic [NUM_SEQ*NUM_OUT-1:0] ctlN,
  output logic [PHASE_BITS-1:0]      phaseCode
);
  localparam int NUM_PHASES = 1 << PHASE_BITS;

  phaseBus_t phaseBus;

  phaseCtl #(
    .PHASE_BITS(PHASE_BITS),
    .NUM_SEQ   (NUM_SEQ)
  ) i_phaseCtl (
    .clk      (clk),
    .rstN     (rstN),
    .seqStrobe(seqStrobe),
    .phaseBus (phaseBus),
    .phaseCode(phaseCode)
  );

  seqBank #(
    .NUM_SEQ   (NUM_SEQ),
    .NUM_OUT   (NUM_OUT),
    .NUM_PHASES(NUM_PHASES),
    .OUT_MASK  (OUT_MASK)
  ) i_seqBank (
    .clk      (clk),
    .rstN     (rstN),
    .seqStrobe(seqStrobe),
    .phaseBus (phaseBus),
    .ctlN     (ctlN)
  );

  // R8
  strobe_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(seqStrobe) <= 1);
endmodule

// File: tb/test_phaseSeqGen.sv
module test_phaseSeqGen;
  // Default instance: 2 sequencers x 3 outputs, 4 phases
  localparam logic [23:0] MASK_A = 24'h823467;
  // Long instance: 1 sequencer x 2 outputs, 8 phases
  localparam logic [15:0] MASK_B = 16'h80FF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] strobeA = '0;
  logic [0:0] strobeB = '0;
  logic [5:0] ctlA;
  logic [1:0] phA;
  logic [1:0] ctlB;
  logic [2:0] phB;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  phaseSeqGen i_phaseSeqGen (
    .clk(clk), .rstN(rstN), .seqStrobe(strobeA), .ctlN(ctlA), .phaseCode(phA));

  phaseSeqGen #(.PHASE_BITS(3), .NUM_SEQ(1), .NUM_OUT(2), .OUT_MASK(MASK_B))
    i_phaseSeqGen_long (
    .clk(clk), .rstN(rstN), .seqStrobe(strobeB), .ctlN(ctlB), .phaseCode(phB));

  typedef struct {
    logic [5:0] eCtlA;
    logic [1:0] ePhA;
    logic [1:0] eCtlB;
    logic [2:0] ePhB;
    string      tag;
  } item_t;

  item_t sbq[$];
  int mdlPhA = 0;
  int mdlPhB = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Driver: one call per clock, drives at negedge and queues the expectation
  task automatic step(input logic [1:0] sA, input logic sB, input string tag);
    item_t it;
    @(negedge clk);
    strobeA = sA;
    strobeB = sB;
    it.eCtlA = '1;
    for (int s = 0; s < 2; s++)
      for (int o = 0; o < 3; o++)
        if (sA[s] && MASK_A[(s*3+o)*4 + mdlPhA]) it.eCtlA[s*3+o] = 1'b0;
    mdlPhA = (sA != 0) ? (mdlPhA + 1) % 4 : 0;
    it.ePhA = 2'(mdlPhA);
    it.eCtlB = '1;
    for (int o = 0; o < 2; o++)
      if (sB && MASK_B[o*8 + mdlPhB]) it.eCtlB[o] = 1'b0;
    mdlPhB = sB ? (mdlPhB + 1) % 8 : 0;
    it.ePhB = 3'(mdlPhB);
    it.tag = tag;
    sbq.push_back(it);
  endtask

  // Monitor: compares one item per clock, 1 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        item_t it;
        int grp;
        it = sbq.pop_front();
        check(ctlA == it.eCtlA, it.tag, "ctlN default", ctlA, it.eCtlA);
        check(phA == it.ePhA, it.tag, "phaseCode default", phA, it.ePhA);
        check(ctlB == it.eCtlB, it.tag, "ctlN long", ctlB, it.eCtlB);
        check(phB == it.ePhB, it.tag, "phaseCode long", phB, it.ePhB);
        // R8: never more than one sequencer with a low output
        grp = int'(~&ctlA[2:0]) + int'(~&ctlA[5:3]);
        check(grp <= 1, "R8", "active groups", grp, 1);
      end
    end
  end

  // Watchdog
  initial begin
    #500000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state, even with a strobe present
    repeat (2) @(negedge clk);
    strobeA = 2'b01;
    strobeB = 1'b1;
    repeat (2) @(negedge clk);
    check(ctlA == 6'h3F, "R1", "ctlN in reset", ctlA, 6'h3F);
    check(phA == 2'd0, "R1", "phaseCode in reset", phA, 0);
    check(ctlB == 2'h3, "R1", "long ctlN in reset", ctlB, 2'h3);
    strobeA = '0;
    strobeB = '0;
    @(negedge clk);
    rstN = 1'b1;

    repeat (3) step(2'b00, 1'b0, "R2");
    // R5: memory-to-register load on sequencer 0
    repeat (3) step(2'b01, 1'b0, "R5");
    step(2'b00, 1'b0, "R7");
    // R4: second sequencer's decode
    repeat (4) step(2'b10, 1'b0, "R4");
    repeat (2) step(2'b00, 1'b0, "R7");
    // R3: wrap past the last phase
    repeat (6) step(2'b01, 1'b0, "R3");
    step(2'b00, 1'b0, "R7");
    // R10: single-cycle strobe
    step(2'b10, 1'b0, "R10");
    repeat (2) step(2'b00, 1'b0, "R10");
    // R6 / R3: hand-off without an idle cycle
    repeat (2) step(2'b01, 1'b0, "R6");
    repeat (3) step(2'b10, 1'b0, "R6");
    step(2'b00, 1'b0, "R7");
    // R9: eight-phase variant, held past T8
    repeat (9) step(2'b00, 1'b1, "R9");
    repeat (2) step(2'b00, 1'b0, "R9");

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule